// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible control register file of a single DMA channel. A host reaches it over a simple register bus that carries 16-bit or 32-bit accesses. The block keeps the channel's programming values: a descriptor pointer, a start address, a configuration word, the inner and outer loop counts and strides, the working copies of pointer and counts, a status word and a peripheral map. The transfer engine that moves the data sits beside it. The engine receives a one-cycle start strobe or stop strobe. It reports completion and faults back through two pulse inputs.

While the channel is running, the block refuses to change anything that the engine depends on. The configuration word and the status word stay writable. Writing the configuration word with its enable bit set arms the channel. The same write loads the working copies from the programmed values. A channel that is the memory-read side of a memory-to-memory pair is left armed but not started, because its partner drives the transfer. Writing the configuration word with the enable bit clear disarms the channel.

Registers sit on a 4-byte stride and are selected by address bits [5:2]; address bits [1:0] are ignored. The slot map is: 0 descriptor pointer, 1 start address, 2 configuration, 3 reserved, 4 inner count, 5 inner stride, 6 outer count, 7 outer stride, 8 working descriptor pointer, 9 working address, 10 status, 11 peripheral map, 12 working inner count, 13 reserved, 14 working outer count, 15 reserved.

Top module: `dmach_regs`

## Requirements
- R1: After reset every register reads zero except the peripheral map, which reads the `PMAP_RST` parameter, and neither strobe is asserted.
- R2: `bus_size` 2'b01 is a 16-bit access and 2'b10 is a 32-bit access. Any other code gives `bus_err` = 1 (bad size) and changes nothing. This holds for reads and writes, and the bad-size code wins over the missing-register code.
- R3: The pointer slots (0, 1, 8, 9) are 32 bits wide, and a 16-bit write changes only their low half. All other slots are 16 bits wide, and a 32-bit write keeps its low 16 bits. A 16-bit read returns the low half, zero-extended.
- R4: While RUN is set, writes to slots 0, 1 and 4 through 9, 11, 12 and 14 are discarded. Those registers keep their values.
- R5: The status word has DONE at bit 0, ERR at bit 1 and RUN at bit 3. Writing 1 to DONE or ERR clears that bit; writing 0 leaves it unchanged. Bus writes never change RUN. If an engine event sets a bit in the same cycle as a clear, the set wins.
- R6: A write to the peripheral map stores all written bits except bit `CTYPE_BIT` (the memory-to-memory type flag), which keeps its value.
- R7: A configuration write with bit 0 (enable) set does three things. It sets RUN. It copies the descriptor pointer and the start address into their working slots. It copies both counts into their working slots, with a count of 0 loaded as 16'hFFFF. The write also pulses `start_pulse` in the next cycle, but only if the type flag is clear or configuration bit 1 (memory-write direction) is set.
- R8: A configuration write with the enable bit clear clears RUN and pulses `stop_pulse` in the next cycle.
- R9: A write to a reserved slot (3, 13, 15) gives `bus_err` = 2 and changes nothing. A read of a reserved slot returns zero with no error.
- R10: Configuration bits [3:2] give the element size: 00 byte, 01 halfword, 10 or 11 word. A start whose start address is not a multiple of the element size sets ERR.
- R11: An `eng_done` pulse sets DONE and clears RUN. An `eng_err` pulse sets ERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| bus_err | output | 2 | 0 ok, 1 bad size, 2 missing register |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine fault pulse |
| start_pulse | output | 1 | Start the transfer engine |
| stop_pulse | output | 1 | Cancel pending engine activity |
| chan_run | output | 1 | RUN status bit |

## Verification
The properties assume that `bus_sel` is held for exactly one clock per access, with all other bus inputs stable over that clock. The lock and clear properties also assume that engine pulses do not arrive in the cycle of the bus write being checked. The stimulus drives every access over a single clock, raises engine pulses only between accesses, and sets the type flag only through the reset parameter of a second instance.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   localparam int unsigned SLOTS = 16;

   localparam int unsigned S_NDP  = 0;
   localparam int unsigned S_SA   = 1;
   localparam int unsigned S_CFG  = 2;
   localparam int unsigned S_XC   = 4;
   localparam int unsigned S_YC   = 6;
   localparam int unsigned S_CDP  = 8;
   localparam int unsigned S_CA   = 9;
   localparam int unsigned S_STAT = 10;
   localparam int unsigned S_PMAP = 11;
   localparam int unsigned S_CXC  = 12;
   localparam int unsigned S_CYC  = 14;

   localparam int unsigned CFG_EN  = 0;
   localparam int unsigned CFG_DIR = 1;
   localparam int unsigned CFG_ESZ = 2;

   localparam int unsigned ST_DONE = 0;
   localparam int unsigned ST_ERR  = 1;
   localparam int unsigned ST_RUN  = 3;

   localparam logic [1:0] SZ_16 = 2'b01;
   localparam logic [1:0] SZ_32 = 2'b10;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_SIZE  = 2'd1,
      ERR_NOREG = 2'd2
   } bus_err_e;

   typedef enum logic [1:0] {
      K_NONE, K_PTR, K_HALF, K_CTRL
   } slot_kind_e;

   function automatic slot_kind_e kind_of(input int unsigned s);
      case (s)
         0, 1, 8, 9:               return K_PTR;
         4, 5, 6, 7, 11, 12, 14:   return K_HALF;
         2, 10:                    return K_CTRL;
         default:                  return K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
   import dmach_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   output logic [SLOT_W-1:0] slot,
   output logic              wide,
   output logic [1:0]        err,
   output logic              wr_fire,
   output logic              rd_fire
);
   logic size_ok;
   logic missing;
   logic [1:0] unused_lo;

   assign unused_lo = addr[1:0];
   assign slot      = addr[SLOT_W+1:2];
   assign wide      = (size == SZ_32);
   assign size_ok   = (size == SZ_16) || (size == SZ_32);
   assign missing   = (kind_of(int'(slot)) == K_NONE);

   always_comb begin
      err = ERR_NONE;
      if (sel) begin
         if (!size_ok)           err = ERR_SIZE;
         else if (wr && missing) err = ERR_NOREG;
      end
   end

   assign wr_fire = sel &&  wr && (err == ERR_NONE);
   assign rd_fire = sel && !wr && (err == ERR_NONE);
endmodule

// File: rtl/dmach_field.sv
module dmach_field #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] RST  = '0,
   parameter logic [W-1:0] KEEP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic         wide,
   input  logic [W-1:0] wdata,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   localparam int unsigned HALF = 16;

   generate
      if (W > HALF) begin : g_split
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= RST;
            else if (ld)  q <= ld_val;
            else if (we) begin
               if (wide) q <= (q & KEEP) | (wdata & ~KEEP);
               else      q[HALF-1:0] <= (q[HALF-1:0] & KEEP[HALF-1:0])
                                      | (wdata[HALF-1:0] & ~KEEP[HALF-1:0]);
            end
         end
      end else begin : g_flat
         logic unused_wide;
         assign unused_wide = wide;
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= RST;
            else if (ld)  q <= ld_val;
            else if (we)  q <= (q & KEEP) | (wdata & ~KEEP);
         end
      end
   endgenerate
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
   import dmach_pkg::*;
#(
   parameter int unsigned CTYPE_BIT = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        stat_we,
   input  logic [15:0] wdata,
   input  logic [1:0]  sa_low,
   input  logic        ctype,
   input  logic        eng_done,
   input  logic        eng_err,
   output logic [15:0] cfg_q,
   output logic [15:0] stat_q,
   output logic        run,
   output logic        load,
   output logic        start_pulse,
   output logic        stop_pulse
);
   logic done_q, err_q;
   logic misalign;
   logic [1:0] esz;
   logic clr_done, clr_err;

   assign load     = cfg_we && wdata[CFG_EN];
   assign esz      = wdata[CFG_ESZ+1:CFG_ESZ];
   assign misalign = (esz == 2'b01 && sa_low[0]) || (esz[1] && (sa_low != 2'b00));
   assign clr_done = stat_we && wdata[ST_DONE];
   assign clr_err  = stat_we && wdata[ST_ERR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         run         <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
      end else begin
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
         if (cfg_we) begin
            cfg_q <= wdata;
            run   <= wdata[CFG_EN];
            if (wdata[CFG_EN]) start_pulse <= !ctype || wdata[CFG_DIR];
            else               stop_pulse  <= 1'b1;
         end else if (eng_done) begin
            run <= 1'b0;
         end
         done_q <= eng_done || (done_q && !clr_done);
         err_q  <= eng_err || (load && misalign) || (err_q && !clr_err);
      end
   end

   always_comb begin
      stat_q          = '0;
      stat_q[ST_DONE] = done_q;
      stat_q[ST_ERR]  = err_q;
      stat_q[ST_RUN]  = run;
   end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
   import dmach_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 32,
   parameter logic [15:0] PMAP_RST  = 16'h0000,
   parameter int unsigned CTYPE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        bus_err,
   input  logic              eng_done,
   input  logic              eng_err,
   output logic              start_pulse,
   output logic              stop_pulse,
   output logic              chan_run
);
   localparam int unsigned SLOT_W = $clog2(SLOTS);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam logic [HALF_W-1:0] CNT_MAX = '1;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("dmach_regs: DATA_W must be 32");
      end
      if (ADDR_W != SLOT_W + 2) begin : g_bad_addr
         $error("dmach_regs: ADDR_W must cover the slot index plus byte offset");
      end
      if (CTYPE_BIT >= HALF_W) begin : g_bad_ctype
         $error("dmach_regs: CTYPE_BIT out of range");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic              wide, wr_fire, rd_fire;
   logic [SLOTS-1:0][DATA_W-1:0] slot_q;
   logic [HALF_W-1:0] cfg_q, stat_q;
   logic              load;

   dmach_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel(bus_sel), .wr(bus_wr), .size(bus_size), .addr(bus_addr),
      .slot(slot), .wide(wide), .err(bus_err),
      .wr_fire(wr_fire), .rd_fire(rd_fire)
   );

   dmach_ctrl #(.CTYPE_BIT(CTYPE_BIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(wr_fire && slot == SLOT_W'(S_CFG)),
      .stat_we(wr_fire && slot == SLOT_W'(S_STAT)),
      .wdata(bus_wdata[HALF_W-1:0]),
      .sa_low(slot_q[S_SA][1:0]),
      .ctype(slot_q[S_PMAP][CTYPE_BIT]),
      .eng_done(eng_done), .eng_err(eng_err),
      .cfg_q(cfg_q), .stat_q(stat_q), .run(chan_run), .load(load),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse)
   );

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         localparam slot_kind_e K = kind_of(s);
         logic we;
         assign we = wr_fire && (slot == SLOT_W'(s)) && !chan_run;

         if (K == K_PTR) begin : g_ptr
            logic [DATA_W-1:0] ld_val;
            logic              ld;
            if (s == S_CDP) begin : g_l
               assign ld = load;  assign ld_val = slot_q[S_NDP];
            end else if (s == S_CA) begin : g_l
               assign ld = load;  assign ld_val = slot_q[S_SA];
            end else begin : g_l
               assign ld = 1'b0;  assign ld_val = '0;
            end
            dmach_field #(.W(DATA_W)) u_fld (
               .clk(clk), .rst_n(rst_n), .we(we), .wide(wide),
               .wdata(bus_wdata), .ld(ld), .ld_val(ld_val), .q(slot_q[s])
            );
         end else if (K == K_HALF) begin : g_half
            localparam logic [HALF_W-1:0] RV = (s == S_PMAP) ? PMAP_RST : '0;
            localparam logic [HALF_W-1:0] KM = (s == S_PMAP) ? (HALF_W'(1) << CTYPE_BIT) : '0;
            logic [HALF_W-1:0] ld_val, q;
            logic              ld;
            if (s == S_CXC || s == S_CYC) begin : g_l
               localparam int unsigned SRC = (s == S_CXC) ? S_XC : S_YC;
               assign ld     = load;
               assign ld_val = (slot_q[SRC][HALF_W-1:0] == '0) ? CNT_MAX
                                                                : slot_q[SRC][HALF_W-1:0];
            end else begin : g_l
               assign ld = 1'b0;  assign ld_val = '0;
            end
            dmach_field #(.W(HALF_W), .RST(RV), .KEEP(KM)) u_fld (
               .clk(clk), .rst_n(rst_n), .we(we), .wide(wide),
               .wdata(bus_wdata[HALF_W-1:0]), .ld(ld), .ld_val(ld_val), .q(q)
            );
            assign slot_q[s] = {{(DATA_W-HALF_W){1'b0}}, q};
         end else if (K == K_CTRL) begin : g_ctrl
            assign slot_q[s] = {{(DATA_W-HALF_W){1'b0}}, (s == S_CFG) ? cfg_q : stat_q};
         end else begin : g_rsv
            logic unused_we;
            assign unused_we = we;
            assign slot_q[s] = '0;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (rd_fire) begin
         bus_rdata = slot_q[slot];
         if (!wide) bus_rdata[DATA_W-1:HALF_W] = '0;
      end
   end
endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk
   import dmach_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTYPE_BIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_size,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        bus_err,
   input logic              eng_done,
   input logic              start_pulse,
   input logic              stop_pulse,
   input logic              chan_run,
   input logic [SLOTS-1:0][DATA_W-1:0] slot_q
);
   logic [3:0] a_slot;
   logic       good_wr;
   assign a_slot  = bus_addr[5:2];
   assign good_wr = bus_sel && bus_wr && (bus_err == 2'd0);

   p_size_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_size != SZ_16 && bus_size != SZ_32) |-> (bus_err == 2'd1));

   p_locked_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && chan_run && a_slot == 4'(S_XC)) |=> $stable(slot_q[S_XC]));

   p_locked_desc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && chan_run && a_slot == 4'(S_NDP)) |=> $stable(slot_q[S_NDP]));

   p_w1c_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && a_slot == 4'(S_STAT) && bus_wdata[ST_DONE] && !eng_done)
      |=> !slot_q[S_STAT][ST_DONE]);

   p_type_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && a_slot == 4'(S_PMAP)) |=> $stable(slot_q[S_PMAP][CTYPE_BIT]));

   p_start_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> chan_run);

   p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> !chan_run);

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_err == 2'd0 && (a_slot == 4'd3 || a_slot == 4'd13))
      |-> (bus_rdata == '0));

   p_done_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !(good_wr && a_slot == 4'(S_CFG))) |=> !chan_run);
endmodule

bind dmach_regs dmach_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTYPE_BIT(CTYPE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .bus_err(bus_err), .eng_done(eng_done),
   .start_pulse(start_pulse), .stop_pulse(stop_pulse),
   .chan_run(chan_run), .slot_q(slot_q)
);

// File: tb/dmach_regs_tb_top.sv
`timescale 1ns/1ps
module dmach_regs_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0;
   logic [1:0]  size = 2'b10;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic [1:0]  err_a, err_b;
   logic done_a = 1'b0, fault_a = 1'b0;
   logic start_a, stop_a, run_a, start_b, stop_b, run_b;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dmach_regs #(.PMAP_RST(16'h0005)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr), .bus_size(size),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .bus_err(err_a),
      .eng_done(done_a), .eng_err(fault_a), .start_pulse(start_a),
      .stop_pulse(stop_a), .chan_run(run_a)
   );

   dmach_regs #(.PMAP_RST(16'h0040)) peer_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr), .bus_size(size),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .bus_err(err_b),
      .eng_done(1'b0), .eng_err(1'b0), .start_pulse(start_b),
      .stop_pulse(stop_b), .chan_run(run_b)
   );

   typedef struct packed {
      logic        w;
      logic [1:0]  sz;
      logic [5:0]  a;
      logic [31:0] d;
      logic [1:0]  er;
      logic        rd_chk;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'b10, 6'h00, 32'h12345678, 2'd0, 1'b0, 32'h0},        // R3 full pointer write
      '{1'b0, 2'b10, 6'h00, 32'h0,        2'd0, 1'b1, 32'h12345678}, // R3
      '{1'b1, 2'b01, 6'h00, 32'hFFFFABCD, 2'd0, 1'b0, 32'h0},        // R3 half write, low only
      '{1'b0, 2'b10, 6'h00, 32'h0,        2'd0, 1'b1, 32'h1234ABCD}, // R3
      '{1'b0, 2'b01, 6'h00, 32'h0,        2'd0, 1'b1, 32'h0000ABCD}, // R3 16-bit read
      '{1'b1, 2'b10, 6'h10, 32'hFFFF0010, 2'd0, 1'b0, 32'h0},        // R3 wide write to half reg
      '{1'b0, 2'b10, 6'h10, 32'h0,        2'd0, 1'b1, 32'h00000010}, // R3
      '{1'b1, 2'b00, 6'h10, 32'h00000077, 2'd1, 1'b0, 32'h0},        // R2 byte write rejected
      '{1'b0, 2'b10, 6'h10, 32'h0,        2'd0, 1'b1, 32'h00000010}, // R2 no effect
      '{1'b1, 2'b11, 6'h0C, 32'h00000001, 2'd1, 1'b0, 32'h0},        // R2 size beats missing reg
      '{1'b1, 2'b10, 6'h0C, 32'hDEADBEEF, 2'd2, 1'b0, 32'h0},        // R9 reserved write
      '{1'b0, 2'b10, 6'h0C, 32'h0,        2'd0, 1'b1, 32'h0},        // R9 reserved read zero
      '{1'b0, 2'b00, 6'h00, 32'h0,        2'd1, 1'b0, 32'h0},        // R2 bad-size read
      '{1'b1, 2'b01, 6'h2C, 32'h0000FFFF, 2'd0, 1'b0, 32'h0},        // R6 type bit kept
      '{1'b0, 2'b01, 6'h2C, 32'h0,        2'd0, 1'b1, 32'h0000FFBF}, // R6
      '{1'b1, 2'b10, 6'h04, 32'h00001000, 2'd0, 1'b0, 32'h0},        // start address
      '{1'b0, 2'b10, 6'h3C, 32'h0,        2'd0, 1'b1, 32'h0}         // R9
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input bit b, input logic w, input logic [1:0] sz, input logic [5:0] a,
                      input logic [31:0] d, output logic [31:0] rd, output logic [1:0] er);
      @(negedge clk);
      sel_a = !b; sel_b = b; wr = w; size = sz; addr = a; wdata = d;
      #1;
      rd = b ? rdata_b : rdata_a;
      er = b ? err_b : err_a;
      @(posedge clk);
      #1;
      sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0;
   endtask

   task automatic wr32(input bit b, input logic [5:0] a, input logic [31:0] d);
      logic [31:0] rd; logic [1:0] er;
      bus(b, 1'b1, 2'b10, a, d, rd, er);
   endtask

   task automatic rd_chk(input bit b, input logic [5:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] rd; logic [1:0] er;
      bus(b, 1'b0, 2'b10, a, 32'h0, rd, er);
      check(tag, rd, exp);
   endtask

   task automatic pulse_chk(input bit b, input logic es, input logic ep, input string tag);
      @(negedge clk);
      check({tag, " start"}, 32'(b ? start_b : start_a), 32'(es));
      check({tag, " stop"},  32'(b ? stop_b  : stop_a),  32'(ep));
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [1:0]  er;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(1'b0, 6'h2C, 32'h0005, "R1 map reset");
      rd_chk(1'b0, 6'h28, 32'h0, "R1 status reset");
      rd_chk(1'b0, 6'h08, 32'h0, "R1 config reset");
      rd_chk(1'b0, 6'h00, 32'h0, "R1 pointer reset");
      rd_chk(1'b1, 6'h2C, 32'h0040, "R1 peer map reset");
      pulse_chk(1'b0, 1'b0, 1'b0, "R1 strobes idle");

      for (int i = 0; i < NV; i++) begin
         bus(1'b0, VEC[i].w, VEC[i].sz, VEC[i].a, VEC[i].d, rd, er);
         check($sformatf("vector %0d err", i), 32'(er), 32'(VEC[i].er));
         if (VEC[i].rd_chk) check($sformatf("vector %0d data", i), rd, VEC[i].exp);
      end

      // R7 start with word elements, outer count zero
      wr32(1'b0, 6'h08, 32'h0000_0009);
      pulse_chk(1'b0, 1'b1, 1'b0, "R7 start strobe");
      rd_chk(1'b0, 6'h28, 32'h0008, "R7 run set");
      rd_chk(1'b0, 6'h24, 32'h0000_1000, "R7 address loaded");
      rd_chk(1'b0, 6'h20, 32'h1234_ABCD, "R7 descriptor loaded");
      rd_chk(1'b0, 6'h30, 32'h0010, "R7 inner count loaded");
      rd_chk(1'b0, 6'h38, 32'hFFFF, "R7 zero count as max");

      // R4 lockout while running
      wr32(1'b0, 6'h10, 32'h55);
      rd_chk(1'b0, 6'h10, 32'h10, "R4 count locked");
      wr32(1'b0, 6'h00, 32'h0);
      rd_chk(1'b0, 6'h00, 32'h1234_ABCD, "R4 pointer locked");
      wr32(1'b0, 6'h2C, 32'h0);
      rd_chk(1'b0, 6'h2C, 32'hFFBF, "R4 map locked");
      wr32(1'b0, 6'h30, 32'h3);
      rd_chk(1'b0, 6'h30, 32'h10, "R4 working count locked");

      // R11 engine completion
      @(negedge clk) done_a = 1'b1;
      @(negedge clk) done_a = 1'b0;
      rd_chk(1'b0, 6'h28, 32'h0001, "R11 done sets DONE clears RUN");

      // R5 write-one-to-clear
      wr32(1'b0, 6'h28, 32'h0);
      rd_chk(1'b0, 6'h28, 32'h0001, "R5 write zero keeps DONE");
      wr32(1'b0, 6'h28, 32'h1);
      rd_chk(1'b0, 6'h28, 32'h0, "R5 write one clears DONE");
      wr32(1'b0, 6'h28, 32'h8);
      rd_chk(1'b0, 6'h28, 32'h0, "R5 RUN not bus-writable");

      // R10 misaligned word start
      wr32(1'b0, 6'h04, 32'h0000_1002);
      wr32(1'b0, 6'h08, 32'h0000_0009);
      pulse_chk(1'b0, 1'b1, 1'b0, "R10 start");
      rd_chk(1'b0, 6'h28, 32'h000A, "R10 misaligned sets ERR");
      wr32(1'b0, 6'h28, 32'h2);
      rd_chk(1'b0, 6'h28, 32'h0008, "R5 ERR cleared");
      @(negedge clk) fault_a = 1'b1;
      @(negedge clk) fault_a = 1'b0;
      rd_chk(1'b0, 6'h28, 32'h000A, "R11 engine error sets ERR");

      // R8 stop
      wr32(1'b0, 6'h08, 32'h0);
      pulse_chk(1'b0, 1'b0, 1'b1, "R8 stop strobe");
      rd_chk(1'b0, 6'h28, 32'h0002, "R8 run cleared");

      // R10 halfword elements accept even address
      wr32(1'b0, 6'h28, 32'h2);
      wr32(1'b0, 6'h08, 32'h0000_0005);
      rd_chk(1'b0, 6'h28, 32'h0008, "R10 halfword aligned no ERR");
      wr32(1'b0, 6'h08, 32'h0);

      // R7 memory-to-memory source waits for its partner
      wr32(1'b1, 6'h08, 32'h0000_0001);
      pulse_chk(1'b1, 1'b0, 1'b0, "R7 source side no start");
      rd_chk(1'b1, 6'h28, 32'h0008, "R7 source side running");
      wr32(1'b1, 6'h08, 32'h0);
      pulse_chk(1'b1, 1'b0, 1'b1, "R8 peer stop");
      wr32(1'b1, 6'h2C, 32'h0);
      rd_chk(1'b1, 6'h2C, 32'h0040, "R6 type bit survives clear");
      wr32(1'b1, 6'h08, 32'h0000_0003);
      pulse_chk(1'b1, 1'b1, 1'b0, "R7 write side starts");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule